// File: doc/BRIEF.md
# Posit to Quire Converter

This block turns one posit operand into the wide fixed-point form used by a quire accumulator. The quire holds a two's-complement number whose binary point sits at the middle of the register, so bit `QW/2` carries the weight 1.0. The posit is split into sign, regime run, exponent and fraction. The significand, with its hidden leading one, is first written so that the hidden one lands exactly on the binary point. It is then walked to its final place by a shifter that moves it left or right by no more than `STEP` bit positions per clock.

A conversion is started with a one-cycle `start`. `busy` then stays high while the value is positioned. `done` pulses for a single clock in the cycle the result appears on `quire_out`. Operands close to 1.0 in magnitude finish in one or two shift cycles. The largest and smallest posits take the most cycles. The posit width, exponent size, quire width and per-cycle step are all parameters. The default is a 16-bit posit with one exponent bit and a 256-bit quire.

Top module: `posit_quire_conv`

## Requirements
- R1: A posit of all zero bits produces a quire of zero and leaves `nar_out` low.
- R2: The pattern with only the top bit set (not-a-real) sets `nar_out` to 1 and produces a quire of zero. Every other pattern clears `nar_out`.
- R3: For a positive posit with scale s = regime * 2^ES + exponent and significand 1.f, `quire_out` equals 1.f * 2^s as a fixed-point number with its weight-1 bit at position QW/2. The regime is k-1 for a run of k ones and -k for a run of k zeros.
- R4: A posit with the top bit set is decoded from its two's complement, and its result is the two's complement (over QW bits) of the result for that magnitude.
- R5: The shifter moves the value by at most STEP (8) positions per clock. `done` rises exactly ceil(|s|/STEP)+1 clocks after the edge that accepts `start`. Zero and not-a-real count as s = 0.
- R6: `busy` is high from the clock after `start` is accepted until the clock in which `done` is high. `done` is high for exactly one clock per conversion and is never high together with `busy`.
- R7: `start` asserted while `busy` is high is ignored. The running conversion keeps its operand and its timing.
- R8: `quire_out` and `nar_out` change only in the cycle `done` is high, and hold their value at all other times, including when `posit_in` changes.
- R9: After reset, `busy`, `done`, `nar_out` and every bit of `quire_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a conversion of `posit_in` (sampled when idle) |
| posit_in | input | PW | Posit operand |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-clock pulse when the result is valid |
| quire_out | output | QW | Fixed-point result, binary point at bit QW/2 |
| nar_out | output | 1 | Operand was not-a-real |

## Verification
The bench aims at scales that are exact multiples of the step and scales one past a multiple. A design whose step accounting is off by one would show the wrong `done` latency there, or leave the value one position out of place. The largest and smallest posits test the full run of regime bits with no terminating bit and a truncated exponent. A decoder that mishandled the missing terminator would give a scale wrong by one regime step. Negative operands, including the negated largest value, show whether the two's complement is taken both on entry and on exit. Pulsing `start` in the middle of a long conversion and then changing `posit_in` after `done` would expose a design that restarts, reloads or lets its output register follow the input.

// File: rtl/pq_pkg.sv
package pq_pkg;

   typedef enum logic [0:0] {
      PQ_IDLE  = 1'b0,
      PQ_SHIFT = 1'b1
   } pq_state_e;

   // Largest magnitude of the scale for a posit of width pw and exponent size es.
   function automatic int pq_max_scale(input int pw, input int es);
      return (pw - 2) << es;
   endfunction

   // Bit width of a signed scale value able to hold +/- pq_max_scale.
   function automatic int pq_scale_width(input int pw, input int es);
      return $clog2(pw << es) + 2;
   endfunction

endpackage

// File: rtl/pq_posit_decode.sv
module pq_posit_decode #(
   parameter int PW = 16,
   parameter int ES = 1,
   parameter int SW = 7,
   parameter int FW = PW - 1 - ES
) (
   input  logic [PW-1:0]        posit,
   output logic                 is_zero,
   output logic                 is_nar,
   output logic signed [SW-1:0] scale,
   output logic [FW-1:0]        frac
);
   localparam int KW = $clog2(PW) + 1;

   logic [PW-2:0] body;
   logic [PW-2:0] rest;
   logic [KW-1:0] run_len;
   logic          lead;
   logic          in_run;
   logic [SW-1:0] regime;
   logic [SW-1:0] exp_ext;

   assign is_zero = (posit == '0);
   assign is_nar  = (posit == {1'b1, {(PW-1){1'b0}}});

   always_comb begin
      body    = posit[PW-1] ? (~posit[PW-2:0] + (PW-1)'(1)) : posit[PW-2:0];
      lead    = body[PW-2];
      run_len = '0;
      in_run  = 1'b1;
      for (int i = PW - 2; i >= 0; i--) begin
         if (in_run && (body[i] == lead)) run_len = run_len + KW'(1);
         else                             in_run  = 1'b0;
      end
      // drop the run and its terminating bit; missing bits shift in as zero
      rest   = body << (run_len + KW'(1));
      regime = lead ? (SW'(run_len) - SW'(1)) : (SW'(0) - SW'(run_len));
   end

   generate
      if (ES > 0) begin : g_exp
         assign exp_ext = SW'(rest[PW-2 -: ES]);
         assign frac    = rest[PW-2-ES:0];
      end else begin : g_noexp
         assign exp_ext = '0;
         assign frac    = rest;
      end
   endgenerate

   assign scale = $signed((regime << ES) + exp_ext);

endmodule

// File: rtl/pq_step_shifter.sv
module pq_step_shifter #(
   parameter int QW   = 256,
   parameter int STEP = 8,
   parameter int AW   = $clog2(STEP + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [QW-1:0] load_val,
   input  logic          en,
   input  logic          left,
   input  logic [AW-1:0] amt,
   output logic [QW-1:0] sr
);
   logic [QW-1:0] cand_l [STEP+1];
   logic [QW-1:0] cand_r [STEP+1];

   generate
      for (genvar j = 0; j <= STEP; j++) begin : g_cand
         assign cand_l[j] = sr << j;
         assign cand_r[j] = sr >> j;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       sr <= '0;
      else if (load) sr <= load_val;
      else if (en)   sr <= left ? cand_l[amt] : cand_r[amt];
   end

   // R5: a single clock never moves the value by more than STEP places
   a_r5_step_bound: assert property (@(posedge clk) disable iff (rst)
      en |-> ((amt != '0) && (int'(amt) <= STEP)));

endmodule

// File: rtl/pq_seq.sv
module pq_seq #(
   parameter int SW   = 7,
   parameter int STEP = 8,
   parameter int AW   = $clog2(STEP + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic                 special,
   input  logic signed [SW-1:0] scale,
   output logic                 load,
   output logic                 en,
   output logic                 left,
   output logic [AW-1:0]        amt,
   output logic                 finish,
   output logic                 busy
);
   import pq_pkg::*;

   pq_state_e     state;
   logic [SW-1:0] remain;
   logic [SW-1:0] mag;

   assign mag    = scale[SW-1] ? (SW'(0) - SW'(scale)) : SW'(scale);
   assign busy   = (state == PQ_SHIFT);
   assign load   = (state == PQ_IDLE) && start;
   assign finish = busy && (remain == '0);
   assign en     = busy && (remain != '0);
   assign amt    = (remain > SW'(STEP)) ? AW'(STEP) : AW'(remain);

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= PQ_IDLE;
         remain <= '0;
         left   <= 1'b0;
      end else if (load) begin
         state  <= PQ_SHIFT;
         remain <= special ? '0 : mag;
         left   <= ~scale[SW-1];
      end else if (finish) begin
         state  <= PQ_IDLE;
      end else if (en) begin
         remain <= remain - SW'(amt);
      end
   end

   // R7: a start pulse during a conversion does not end or restart it
   a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
      (busy && start && !finish) |=> busy);

   // R6: the shift phase always ends in exactly one finish cycle
   a_r6_finish_leaves: assert property (@(posedge clk) disable iff (rst)
      finish |=> !busy);

endmodule

// File: rtl/posit_quire_conv.sv
module posit_quire_conv #(
   parameter int PW   = 16,
   parameter int ES   = 1,
   parameter int QW   = 16 * PW,
   parameter int STEP = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [PW-1:0] posit_in,
   output logic          busy,
   output logic          done,
   output logic [QW-1:0] quire_out,
   output logic          nar_out
);
   import pq_pkg::*;

   localparam int SW   = pq_scale_width(PW, ES);
   localparam int FW   = PW - 1 - ES;
   localparam int QF   = QW / 2;
   localparam int MAXS = pq_max_scale(PW, ES);
   localparam int AW   = $clog2(STEP + 1);

   generate
      if (PW < ES + 4)       begin : g_bad_pw   $error("posit width too small for ES"); end
      if (STEP < 1)          begin : g_bad_step $error("STEP must be at least 1"); end
      if (QF < FW + MAXS)    begin : g_bad_lo   $error("quire too narrow below the point"); end
      if (QF + MAXS >= QW-1) begin : g_bad_hi   $error("quire too narrow above the point"); end
   endgenerate

   logic                 is_zero, is_nar, special;
   logic signed [SW-1:0] scale;
   logic [FW-1:0]        frac;
   logic                 load, en, left, finish;
   logic [AW-1:0]        amt;
   logic [QW-1:0]        centred, sr;
   logic                 neg_q, nar_q;

   pq_posit_decode #(.PW(PW), .ES(ES), .SW(SW), .FW(FW)) u_dec (
      .posit(posit_in), .is_zero(is_zero), .is_nar(is_nar),
      .scale(scale), .frac(frac));

   assign special = is_zero | is_nar;
   assign centred = special ? '0 : (QW'({1'b1, frac}) << (QF - FW));

   pq_seq #(.SW(SW), .STEP(STEP), .AW(AW)) u_seq (
      .clk(clk), .rst(rst), .start(start), .special(special), .scale(scale),
      .load(load), .en(en), .left(left), .amt(amt), .finish(finish), .busy(busy));

   pq_step_shifter #(.QW(QW), .STEP(STEP), .AW(AW)) u_shf (
      .clk(clk), .rst(rst), .load(load), .load_val(centred),
      .en(en), .left(left), .amt(amt), .sr(sr));

   always_ff @(posedge clk) begin
      if (rst) begin
         done      <= 1'b0;
         quire_out <= '0;
         nar_out   <= 1'b0;
         neg_q     <= 1'b0;
         nar_q     <= 1'b0;
      end else begin
         done <= finish;
         if (load) begin
            neg_q <= posit_in[PW-1];
            nar_q <= is_nar;
         end
         if (finish) begin
            quire_out <= neg_q ? (~sr + QW'(1)) : sr;
            nar_out   <= nar_q;
         end
      end
   end

   // R6: done lasts one clock
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R6: done and busy are never high together
   a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);

   // R8: result holds outside the done cycle
   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      !done |-> ($stable(quire_out) && $stable(nar_out)));

   // R2: a not-a-real result carries a zero quire
   a_r2_nar_zero: assert property (@(posedge clk) disable iff (rst)
      nar_out |-> (quire_out == '0));

endmodule

// File: tb/tb_posit_quire_conv.sv
module tb_posit_quire_conv;
   localparam int PW   = 16;
   localparam int ES   = 1;
   localparam int QW   = 16 * PW;
   localparam int QF   = QW / 2;
   localparam int STEP = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [PW-1:0] posit_in = '0;
   logic          busy, done, nar_out;
   logic [QW-1:0] quire_out;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   posit_quire_conv #(.PW(PW), .ES(ES), .QW(QW), .STEP(STEP)) dut (
      .clk(clk), .rst(rst), .start(start), .posit_in(posit_in),
      .busy(busy), .done(done), .quire_out(quire_out), .nar_out(nar_out));

   task automatic chk(input bit ok, input string req, input logic [QW-1:0] act,
                      input logic [QW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Independent reference: walk the bits of the magnitude one by one.
   function automatic logic [QW-1:0] ref_quire(input logic [PW-1:0] p, output int sc);
      logic [PW-1:0] m;
      logic [QW-1:0] sig;
      int i, k, rg, e, fb;
      logic lead;
      sc = 0;
      if (p == '0 || p == {1'b1, {(PW-1){1'b0}}}) return '0;
      m = p[PW-1] ? -p : p;
      i = PW - 2; lead = m[i]; k = 0;
      while (i >= 0 && m[i] == lead) begin k++; i--; end
      i--;
      rg = lead ? k - 1 : -k;
      e = 0;
      for (int j = 0; j < ES; j++) begin
         e = e << 1;
         if (i >= 0) e = e | int'(m[i]);
         i--;
      end
      sig = QW'(1); fb = 0;
      while (i >= 0) begin sig = (sig << 1) | QW'(m[i]); fb++; i--; end
      sc = rg * (1 << ES) + e;
      sig = sig << (QF + sc - fb);
      return p[PW-1] ? -sig : sig;
   endfunction

   // Run one conversion and check value, flag, latency and busy.
   task automatic convert(input logic [PW-1:0] p, input bit poke_mid);
      int sc, cyc, expc;
      logic [QW-1:0] expq;
      bit isnar;
      expq  = ref_quire(p, sc);
      isnar = (p == {1'b1, {(PW-1){1'b0}}});
      expc  = ((sc < 0 ? -sc : sc) + STEP - 1) / STEP + 1;
      posit_in = p; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R6 busy after start", QW'(busy), QW'(1));
      cyc = 0;
      while (done !== 1'b1 && cyc < 100) begin
         if (poke_mid && cyc == 1) begin start = 1'b1; posit_in = 16'h4000; end
         else begin start = 1'b0; end
         @(negedge clk); cyc++;
         if (done !== 1'b1)
            chk(busy === 1'b1, "R6 busy held", QW'(busy), QW'(1));
      end
      start = 1'b0;
      chk(cyc == expc, "R5 latency", QW'(cyc), QW'(expc));
      chk(busy === 1'b0, "R6 busy low with done", QW'(busy), QW'(0));
      chk(quire_out === expq, p[PW-1] ? "R4 value" : (p == 0 ? "R1 value" : "R3 value"),
          quire_out, expq);
      chk(nar_out === isnar, "R2 flag", QW'(nar_out), QW'(isnar));
      @(negedge clk);
      chk(done === 1'b0, "R6 single pulse", QW'(done), QW'(0));
   endtask

   task automatic t_reset();
      chk(busy === 1'b0 && done === 1'b0, "R9 control", QW'({busy, done}), QW'(0));
      chk(quire_out === '0 && nar_out === 1'b0, "R9 data", quire_out, '0);
   endtask

   task automatic t_specials();
      convert(16'h0000, 1'b0);          // R1 zero
      convert(16'h8000, 1'b0);          // R2 not-a-real
      convert(16'h4000, 1'b0);          // R3 one
      convert(16'hC000, 1'b0);          // R4 minus one
   endtask

   task automatic t_extremes();
      convert(16'h7FFF, 1'b0);          // R3 maxpos, scale 28
      convert(16'h0001, 1'b0);          // R3 minpos, scale -28
      convert(16'h8001, 1'b0);          // R4 negated maxpos
      convert(16'hFFFF, 1'b0);          // R4 negated minpos
      convert(16'h7C00, 1'b0);          // R5 scale 8, one step
      convert(16'h7D00, 1'b0);          // R5 scale 9, two steps
      convert(16'h0400, 1'b0);          // R5 scale -8
      convert(16'h2000, 1'b0);          // R3 scale -2
   endtask

   task automatic t_start_ignored();
      convert(16'h7FFF, 1'b1);          // R7 start pulsed mid conversion
   endtask

   task automatic t_hold();
      logic [QW-1:0] keep;
      keep = quire_out;
      posit_in = 16'h1234;
      repeat (5) @(negedge clk);
      chk(quire_out === keep, "R8 hold", quire_out, keep);
      chk(done === 1'b0 && busy === 1'b0, "R8 idle", QW'({busy, done}), QW'(0));
   endtask

   task automatic t_random();
      logic [PW-1:0] lf = 16'hACE1;
      for (int n = 0; n < 40; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         convert(lf, 1'b0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_specials();
      t_extremes();
      t_start_ignored();
      t_hold();
      t_random();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule